// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital timing and control core of an 8-bit successive-approximation converter that reports its result one bit at a time on a single data pin. A fixed 12-clock frame is run for each conversion. A frame starts at the rising clock edge that finds the active-low start line low, and that edge is clock 1. Clocks 1 and 2 give the analog side time for calibration and input tracking. The input is held at the falling edge of clock 3. Clocks 4 to 11 each decide one result bit, MSB first. Each decided bit goes out on the data pin at the falling edge of its clock. The block drives a trial code to an external DAC/comparator and reads back one comparator bit.

The data pin is modelled as a value plus an output-enable. The pin is driven low from the start of a frame until the MSB appears, and it is pulled low again at the rising edge of clock 12. At the falling edge of clock 12 the start line is sampled. If it is high, the pin is released to high impedance and the block idles (single-shot use). If it is low, the pin stays driven and, provided the line is still low at the next rising edge, the next frame follows at once (free-run use). If the line goes low only after that falling edge but before the next rising edge, the pin is released for half a clock and the next frame still starts without a gap (synchronous use).

Top module: `sar_serial_seq`

## Requirements
- R1: A frame begins at the rising edge that samples start_n low while idle; that edge is clock 1, sdata_oe rises with it, and a frame lasts exactly 12 clocks.
- R2: From clock 1 until the falling edge of clock 4, sdata_oe is 1 and sdata is 0.
- R3: hold rises at the falling edge of clock 3 and falls at the falling edge of clock 12, and it is 0 while idle (1 means hold, 0 means track).
- R4: Result bit 7 (the MSB) appears on sdata at the falling edge of clock 4. Bit 11-k appears at the falling edge of clock k, for k from 4 to 11. Changes of the analog input after the falling edge of clock 3 do not alter the result.
- R5: The result is straight binary. With an ideal comparator (cmp_hi = 1 when the held input is at or above trial_code), the serial bits equal the held input code, including 0x00 and 0xFF.
- R6: During the high phase of clock k (4..11), trial_code has bit 11-k set, the bits above it equal the bits already decided, and the bits below it are 0.
- R7: sdata returns to 0 at the rising edge of clock 12, so the LSB is valid only in the low phase of clock 11.
- R8: If start_n is high at the falling edge of clock 12, sdata_oe drops to 0 there and the block stays idle (sdata_oe 0, hold 0) until start_n is sampled low.
- R9: If start_n is low at the falling edge of clock 12 and at the next rising edge, sdata_oe stays 1 and the next frame's clock 1 begins at that rising edge.
- R10: If start_n goes low after the falling edge of clock 12 and before the next rising edge, sdata_oe is 0 for that low phase and the next frame still begins at the next rising edge.
- R11: A synchronous active-high reset forces idle: sdata_oe 0, sdata 0, hold 0, frame counter cleared.
- R12: Changes of start_n during clocks 1 to 11 have no effect on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, 12 per sample |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low start-convert line |
| cmp_hi | input | 1 | Comparator result: 1 when held input is at or above trial_code |
| trial_code | output | 8 | Trial code to the external DAC/comparator |
| hold | output | 1 | Track/hold control, 1 = hold |
| sdata | output | 1 | Serial result value for the data pin |
| sdata_oe | output | 1 | Data pin drive enable, 0 = high impedance |

## Verification
Frame start and the return to low at clock 12 follow the rising edge with no extra register, so they are checked 1 ns after that same edge. Result bits, hold, and the release decision belong to the falling edge of the same clock, so they are checked 1 ns after that falling edge. The trial code for bit 11-k is checked in the high phase of clock k. The bench checks every clock of every frame in both phases, against values it computes from the chosen input code and the start-line pattern. The start line and the analog input change only half a nanosecond after a rising edge, or 1.5 ns after the falling edge of clock 12, so no check samples a value that is changing.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int SAR_BITS_DEF  = 8;
    localparam int PREP_CLKS_DEF = 2;

    typedef enum logic [2:0] {
        SEG_IDLE,
        SEG_PREP,
        SEG_SAMPLE,
        SEG_BIT,
        SEG_END
    } seg_e;

    typedef struct packed {
        logic drive;
        logic level;
        logic hold;
    } line_t;

    function automatic int frame_len(input int prep, input int bits);
        return prep + bits + 2;
    endfunction

    function automatic seg_e seg_of(input int ph, input int prep, input int bits);
        if (ph == 0)
            return SEG_IDLE;
        else if (ph <= prep)
            return SEG_PREP;
        else if (ph == prep + 1)
            return SEG_SAMPLE;
        else if (ph <= prep + 1 + bits)
            return SEG_BIT;
        else
            return SEG_END;
    endfunction

    function automatic int bit_of(input int ph, input int prep, input int bits);
        return prep + bits + 1 - ph;
    endfunction

endpackage

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
    import sar_seq_pkg::*;
#(
    parameter int BITS = SAR_BITS_DEF,
    parameter int PREP = PREP_CLKS_DEF,
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_n,
    output logic [PH_W-1:0] phase,
    output seg_e            seg
);

    localparam int FRAME = frame_len(PREP, BITS);

    always_comb seg = seg_of(int'(phase), PREP, BITS);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            unique case (seg)
                SEG_IDLE: if (!start_n) phase <= PH_W'(1);
                SEG_END:  phase <= start_n ? '0 : PH_W'(1);
                default:  phase <= phase + PH_W'(1);
            endcase
        end
    end

    assert_frame_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (seg != SEG_IDLE && seg != SEG_END) |=> (phase == $past(phase) + PH_W'(1)));

    assert_idle_start_R1: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_IDLE && !start_n) |=> (phase == PH_W'(1)));

    assert_chain_next_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_W'(FRAME) && !start_n) |=> (phase == PH_W'(1)));

    assert_single_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_W'(FRAME) && start_n) |=> (phase == '0));

endmodule

// File: rtl/sar_approx.sv
module sar_approx
    import sar_seq_pkg::*;
#(
    parameter int BITS = SAR_BITS_DEF,
    parameter int PREP = PREP_CLKS_DEF,
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] phase,
    input  seg_e            seg,
    input  logic            cmp_hi,
    output logic [BITS-1:0] trial_code
);

    localparam int IW = (BITS > 1) ? $clog2(BITS) : 1;

    logic [BITS-1:0] decided;
    logic [BITS-1:0] probe;
    logic [IW-1:0]   bidx;

    always_comb begin
        if (seg == SEG_BIT)
            bidx = IW'(bit_of(int'(phase), PREP, BITS));
        else
            bidx = '0;
    end

    for (genvar i = 0; i < BITS; i++) begin : g_slice
        always_ff @(negedge clk) begin
            if (rst)
                decided[i] <= 1'b0;
            else if (seg == SEG_PREP || seg == SEG_SAMPLE)
                decided[i] <= 1'b0;
            else if (seg == SEG_BIT && bidx == IW'(i))
                decided[i] <= cmp_hi;
        end

        always_comb probe[i] = (seg == SEG_BIT) && (bidx == IW'(i));
    end

    always_comb trial_code = decided | probe;

    assert_clear_before_bits_R6: assert property (@(negedge clk) disable iff (rst)
        (seg == SEG_SAMPLE) |=> (decided == '0));

endmodule

// File: rtl/sar_line_drive.sv
module sar_line_drive
    import sar_seq_pkg::*;
#(
    parameter int BITS = SAR_BITS_DEF,
    parameter int PREP = PREP_CLKS_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  seg_e  seg,
    input  logic  start_n,
    input  logic  cmp_hi,
    output line_t line_q
);

    localparam int FRAME = frame_len(PREP, BITS);

    always_ff @(negedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q.level <= (seg == SEG_BIT) ? cmp_hi : 1'b0;
            line_q.hold  <= (seg == SEG_SAMPLE) || (seg == SEG_BIT);
            line_q.drive <= (seg != SEG_IDLE) && !(seg == SEG_END && start_n);
        end
    end

    assert_hold_through_bits_R3: assert property (@(negedge clk) disable iff (rst)
        (seg == SEG_BIT) |=> line_q.hold);

    assert_release_on_high_R8: assert property (@(negedge clk) disable iff (rst)
        (seg == SEG_END && start_n) |=> !line_q.drive);

    initial begin
        assert_frame_shape_R1: assert (FRAME == PREP + BITS + 2);
    end

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sar_seq_pkg::*;
#(
    parameter int BITS = SAR_BITS_DEF,
    parameter int PREP = PREP_CLKS_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_n,
    input  logic            cmp_hi,
    output logic [BITS-1:0] trial_code,
    output logic            hold,
    output logic            sdata,
    output logic            sdata_oe
);

    localparam int FRAME = frame_len(PREP, BITS);
    localparam int PH_W  = $clog2(FRAME + 1);

    logic [PH_W-1:0] phase;
    seg_e            seg;
    line_t           line_q;

    sar_frame_ctl #(.BITS(BITS), .PREP(PREP), .PH_W(PH_W)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .phase   (phase),
        .seg     (seg)
    );

    sar_approx #(.BITS(BITS), .PREP(PREP), .PH_W(PH_W)) u_sar (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .seg        (seg),
        .cmp_hi     (cmp_hi),
        .trial_code (trial_code)
    );

    sar_line_drive #(.BITS(BITS), .PREP(PREP)) u_line (
        .clk     (clk),
        .rst     (rst),
        .seg     (seg),
        .start_n (start_n),
        .cmp_hi  (cmp_hi),
        .line_q  (line_q)
    );

    // Clock 12 pulls the pin low at its rising edge; the release follows at its falling edge.
    always_comb begin
        sdata    = line_q.level && (seg != SEG_END);
        sdata_oe = line_q.drive || (seg == SEG_PREP) || (seg == SEG_SAMPLE) || (seg == SEG_BIT);
        hold     = line_q.hold;
    end

    assert_pre_data_low_R2: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_PREP || seg == SEG_SAMPLE) |-> (sdata_oe && !sdata));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_IDLE && $past(seg == SEG_IDLE)) |-> (!sdata_oe && !hold));

endmodule

// File: tb/sar_serial_seq_test.sv
`timescale 1ns/100ps
module sar_serial_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_n = 1'b1;
    logic       cmp_hi;
    logic [7:0] trial_code;
    logic       hold;
    logic       sdata;
    logic       sdata_oe;

    logic [7:0] vin = 8'h00;
    logic [7:0] vheld = 8'h00;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sar_serial_seq uut (
        .clk        (clk),
        .rst        (rst),
        .start_n    (start_n),
        .cmp_hi     (cmp_hi),
        .trial_code (trial_code),
        .hold       (hold),
        .sdata      (sdata),
        .sdata_oe   (sdata_oe)
    );

    // Ideal track/hold and comparator model.
    always @(posedge hold) vheld = vin;
    assign cmp_hi = (vheld >= trial_code);

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_trial(input int v, input int b);
        return ((v >> (b + 1)) << (b + 1)) | (1 << b);
    endfunction

    function automatic int exp_line_low(input int v, input int k);
        return (k >= 4 && k <= 11) ? ((v >> (11 - k)) & 1) : 0;
    endfunction

    function automatic int exp_line_high(input int v, input int k);
        return (k >= 5 && k <= 11) ? ((v >> (12 - k)) & 1) : 0;
    endfunction

    // mode: 0 single shot, 1 free run, 2 late restart, 3 early restart
    task automatic run_frame(input logic [7:0] v, input int mode, input bit wiggle);
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk);
            #0.5;
            if (k == 1) begin
                vin = v;
                start_n = (mode == 1) ? 1'b0 : 1'b1;
            end
            if (k == 5) vin = ~v;               // R4: input moves after sampling
            if (wiggle && k == 6) start_n = 1'b0; // R12
            if (wiggle && k == 8) start_n = 1'b1; // R12
            if (k == 12 && mode == 3) start_n = 1'b0;
            #0.5;
            chk($sformatf("R1 oe high phase clk%0d", k), int'(sdata_oe), 1);
            if (k <= 4) chk($sformatf("R2 pre-data high clk%0d", k), int'(sdata), 0);
            else if (k == 12) chk("R7 low at clk12 rise", int'(sdata), 0);
            else chk($sformatf("R4 bit high clk%0d", k), int'(sdata), exp_line_high(v, k));
            if (k >= 4 && k <= 11)
                chk($sformatf("R6 trial clk%0d", k), int'(trial_code), exp_trial(v, 11 - k));
            chk($sformatf("R3 hold high clk%0d", k), int'(hold), (k >= 4) ? 1 : 0);
            @(negedge clk);
            #1;
            if (k < 12) chk($sformatf("R1 oe low phase clk%0d", k), int'(sdata_oe), 1);
            else if (mode == 0) chk("R8 release at clk12 fall", int'(sdata_oe), 0);
            else if (mode == 2) chk("R10 release before late start", int'(sdata_oe), 0);
            else chk("R9 keep driving at clk12 fall", int'(sdata_oe), 1);
            if (k <= 3) chk($sformatf("R2 pre-data low clk%0d", k), int'(sdata), 0);
            else chk($sformatf("R5 bit low clk%0d v=%0d", k, v), int'(sdata), exp_line_low(v, k));
            chk($sformatf("R3 hold low clk%0d", k), int'(hold), (k >= 3 && k <= 11) ? 1 : 0);
            if (k == 12 && mode == 2) begin
                #0.5;
                start_n = 1'b0;
            end
        end
    endtask

    task automatic idle_then_start(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            chk("R8 idle oe", int'(sdata_oe), 0);
            chk("R8 idle hold", int'(hold), 0);
        end
        #0.5;
        start_n = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        chk("R11 reset oe", int'(sdata_oe), 0);
        chk("R11 reset sdata", int'(sdata), 0);
        chk("R11 reset hold", int'(hold), 0);
        #0.5;
        rst = 1'b0;

        idle_then_start(2);
        run_frame(8'h00, 1, 0);
        run_frame(8'hFF, 1, 0);
        run_frame(8'h80, 3, 0);
        run_frame(8'h01, 2, 0);
        run_frame(8'h5A, 0, 1);
        idle_then_start(3);

        for (int f = 0; f < 24; f++) begin
            logic [7:0] v;
            int mode;
            v = 8'($urandom);
            mode = (f == 23) ? 0 : int'($urandom % 4);
            run_frame(v, mode, (mode == 0) && ($urandom % 2 == 1));
            if (mode == 0) idle_then_start(1 + int'($urandom % 3));
        end

        // Reset in the middle of a frame (R11).
        repeat (5) @(posedge clk);
        #0.5;
        rst = 1'b1;
        start_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R11 mid-frame reset oe", int'(sdata_oe), 0);
        chk("R11 mid-frame reset hold", int'(hold), 0);
        chk("R11 mid-frame reset sdata", int'(sdata), 0);
        #0.5;
        rst = 1'b0;
        idle_then_start(2);
        run_frame(8'hC3, 0, 0);
        idle_then_start(1);
        run_frame(8'h7F, 0, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule